// File: doc/BRIEF.md
# Periodic cache miss address sampler

This block keeps a statistical sample of cache miss addresses for performance monitoring. A free-running 6-bit counter advances on every miss strobe. When a miss takes the counter from its top value back to zero, the address of that miss is latched into a sample register and a valid flag is raised. A new sample is taken only when the previous one has been consumed.

Software reads three values: the live counter, the valid flag, and the sample register. Bit 0 of the sample register reads back as a copy of the valid flag. Software clears the flag by pulsing a write-one-to-clear strobe. While the flag is set, later wraps leave the held address untouched. The counter keeps running throughout.

Top module: `miss_sampler`

## Requirements
- R1: After reset, `count_o` is 6'b111110 (62), `valid_o` is 0 and `sample_o` is all zero.
- R2: Each cycle with `miss_i` high advances `count_o` by one modulo 64. A cycle with `miss_i` low leaves it unchanged, whatever the valid flag holds.
- R3: A miss seen while `count_o` is 63 (the wrap miss) with the valid flag clear stores `miss_addr_i[ADDR_W-1:1]` into `sample_o[ADDR_W-1:1]` and sets `valid_o` one cycle later.
- R4: A wrap miss while `valid_o` is 1 and `clr_valid_i` is low leaves `sample_o` and `valid_o` unchanged.
- R5: `clr_valid_i` high in a cycle with no wrap miss clears `valid_o` on the next cycle and leaves `sample_o[ADDR_W-1:1]` unchanged.
- R6: If `clr_valid_i` and a wrap miss fall in the same cycle, the wrap miss address is captured and `valid_o` stays at 1.
- R7: `sample_o[0]` always equals `valid_o`.
- R8: Because of the reset value, the second miss after reset is the first one sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_i | input | 1 | One-cycle strobe per cache miss |
| miss_addr_i | input | ADDR_W | Address of the current miss |
| clr_valid_i | input | 1 | Write-one-to-clear strobe for the valid flag |
| count_o | output | CNT_W | Live miss counter |
| valid_o | output | 1 | A sample is held |
| sample_o | output | ADDR_W | Sampled address; bit 0 is a copy of valid_o |

## Verification
The hardest case to reach is a clear strobe that lands exactly on the wrap miss. This needs a held sample and a counter sitting at 63 at the same time. The directed part of the stimulus first fills the sample. It then issues misses one at a time until the reference counter reads 63, and drives the clear together with the next miss. Long random runs add further wraps, some with the flag set and some with it clear, while software-style clears arrive at arbitrary times.

// File: rtl/miss_sampler_pkg.sv
package miss_sampler_pkg;
  localparam int unsigned DEF_CNT_W  = 6;
  localparam int unsigned DEF_ADDR_W = 32;

  // all ones except bit 0
  function automatic logic [31:0] cnt_rst_val(input int unsigned w);
    logic [31:0] v;
    v = (32'd1 << w) - 32'd2;
    return v;
  endfunction
endpackage

// File: rtl/miss_counter.sv
module miss_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(miss_sampler_pkg::cnt_rst_val(CNT_W));
  localparam logic [CNT_W-1:0] TOP_VAL = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (miss_i) cnt_q <= cnt_q + ONE;
  end

  assign count_o = cnt_q;
  assign wrap_o  = miss_i && (cnt_q == TOP_VAL);

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> count_o == CNT_W'($past(count_o) + ONE));
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> $stable(count_o));
endmodule

// File: rtl/miss_capture.sv
module miss_capture #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:1] addr_o
);
  logic              valid_q;
  logic [ADDR_W-1:1] addr_q;
  logic              take;

  // a clear in the same cycle frees the slot for this wrap
  assign take = wrap_i && (!valid_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (take)       valid_q <= 1'b1;
      else if (clr_i) valid_q <= 1'b0;
      if (take)       addr_q  <= addr_i[ADDR_W-1:1];
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !valid_o) |=> (valid_o && addr_o == $past(addr_i[ADDR_W-1:1])));
  a_r4_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && valid_o && !clr_i) |=> ($stable(addr_o) && valid_o));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wrap_i) |=> (!valid_o && $stable(addr_o)));
  a_r6_clear_vs_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && wrap_i) |=> (valid_o && addr_o == $past(addr_i[ADDR_W-1:1])));
endmodule

// File: rtl/miss_sampler.sv
module miss_sampler #(
  parameter int unsigned CNT_W  = miss_sampler_pkg::DEF_CNT_W,
  parameter int unsigned ADDR_W = miss_sampler_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              clr_valid_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] sample_o
);
  logic              wrap;
  logic [ADDR_W-1:1] held_addr;

  miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .miss_i  (miss_i),
    .count_o (count_o),
    .wrap_o  (wrap)
  );

  miss_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .clr_i   (clr_valid_i),
    .addr_i  (miss_addr_i),
    .valid_o (valid_o),
    .addr_o  (held_addr)
  );

  assign sample_o = {held_addr, valid_o};
endmodule

// File: tb/miss_sampler_bench.sv
module miss_sampler_bench;
  localparam int unsigned CW = 6;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          miss_i = 1'b0;
  logic [AW-1:0] miss_addr_i = '0;
  logic          clr_valid_i = 1'b0;
  logic [CW-1:0] count_o;
  logic          valid_o;
  logic [AW-1:0] sample_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  int unsigned   m_cnt;
  bit            m_valid;
  logic [AW-1:1] m_addr;

  always #2 clk_i = ~clk_i;

  miss_sampler #(.CNT_W(CW), .ADDR_W(AW)) u_miss_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .miss_i(miss_i), .miss_addr_i(miss_addr_i),
    .clr_valid_i(clr_valid_i), .count_o(count_o), .valid_o(valid_o), .sample_o(sample_o)
  );

  function automatic bit is_wrap(input bit m, input int unsigned c);
    return m && (c == 63);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 count"}, 64'(count_o), 64'(m_cnt));
    chk({tag, " valid"}, 64'(valid_o), 64'(m_valid));
    chk({tag, " sample"}, 64'(sample_o[AW-1:1]), 64'(m_addr));
    chk("R7 bit0", 64'(sample_o[0]), 64'(valid_o));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit m, input logic [AW-1:0] a, input bit c, input string tag);
    bit w;
    miss_i = m; miss_addr_i = a; clr_valid_i = c;
    @(posedge clk_i);
    w = is_wrap(m, m_cnt);
    if (w && (!m_valid || c)) begin m_valid = 1'b1; m_addr = a[AW-1:1]; end
    else if (c) m_valid = 1'b0;
    if (m) m_cnt = (m_cnt + 1) % 64;
    @(negedge clk_i);
    check_all(tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    void'($urandom(32'd2024));
    m_cnt = 62; m_valid = 0; m_addr = '0;
    repeat (3) @(negedge clk_i);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 count", 64'(count_o), 64'd62);
    chk("R1 valid", 64'(valid_o), 64'd0);
    chk("R1 sample", 64'(sample_o), 64'd0);

    // R8: second miss is sampled
    step(1'b0, 32'h0, 1'b0, "R2 idle");
    step(1'b1, 32'h1111_1110, 1'b0, "R8 first miss");
    chk("R8 not yet", 64'(valid_o), 64'd0);
    step(1'b1, 32'hABCD_0123, 1'b0, "R8 second miss");
    chk("R8 R3 captured", 64'(sample_o), 64'hABCD_0123);
    held = sample_o;

    // R4: wrap while valid is blocked, counter keeps going
    while (m_cnt != 63) step(1'b1, 32'h5555_5554, 1'b0, "R4 run");
    step(1'b1, 32'h7777_7776, 1'b0, "R4 blocked wrap");
    chk("R4 held", 64'(sample_o), 64'(held));
    chk("R4 count", 64'(count_o), 64'd0);

    // R5: clear without wrap
    step(1'b1, 32'h0, 1'b1, "R5 clear");
    chk("R5 valid", 64'(valid_o), 64'd0);
    chk("R5 addr", 64'(sample_o[AW-1:1]), 64'(held[AW-1:1]));

    // refill then R6: clear coincident with wrap
    while (m_cnt != 63) step(1'b1, 32'h2, 1'b0, "R3 run");
    step(1'b1, 32'h1357_9BDF, 1'b0, "R3 refill");
    while (m_cnt != 63) step(1'b1, 32'h4, 1'b0, "R6 run");
    step(1'b1, 32'h2468_ACE0, 1'b1, "R6 clear+wrap");
    chk("R6 valid", 64'(valid_o), 64'd1);
    chk("R6 addr", 64'(sample_o), 64'h2468_ACE1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, $urandom, ($urandom % 16) == 0, "rand R3 R4 R5 R6");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule